// File: doc/BRIEF.md
# General-Purpose I/O Bank with Edge and Level Interrupt Sensing

This block controls a bank of general-purpose pins, 16 wide by default, through a register port with one access per cycle. Software sets each pin as a driven output or a sampled input. Each input pin has its own input buffer enable, which is off after reset. An enabled input is brought into the system clock domain through a fixed synchronizer. It is then sensed either as a level or as a sticky edge capture. Masked sensed pins combine into a single interrupt request.

A per-pin function-enable bit gives the pin's output driver to a peripheral, so the GPIO drive is withheld. Input sensing keeps watching the pin while the bit is set. All latencies are fixed. A pin change reaches the readback after the third rising clock edge. A level interrupt follows after the fourth edge and an edge interrupt after the fifth.

Top module: `gpio_bank`

## Requirements
- R1: After reset, every register reads 0, pin_oe is 0 and irq is 0. All pins are therefore inputs with their input buffers off, owned by the GPIO and unmasked-off.
- R2: pin_out always carries the data register. pin_oe bit i is 1 exactly when direction bit i is 1 (1 = output, 0 = input) and function-enable bit i is 0.
- R3: A write to address 0 (data) changes only the bits whose direction bit is 1. A read of address 0 returns the data register for output bits and the sensed state for input bits.
- R4: A pin is sampled only while its input-enable bit is set, and its sensed state is 0 while the bit is clear. A level change on an enabled pin shows in the readback after the third rising clock edge that follows it.
- R5: With edge-select 0 (level), the sensed state is the synchronized pin XOR its polarity bit, so polarity 1 is active-low. With edge-select 1 and both-edges 0, polarity 0 captures rising edges and polarity 1 captures falling edges.
- R6: In edge mode a captured edge holds the sensed bit at 1 until software writes a 1 to that bit at address 8 (clear). An edge detected in the same cycle as the clear write keeps the bit set.
- R7: With both-edges 1 on an edge-mode pin, both rising and falling edges are captured, whatever the polarity bit.
- R8: irq is the OR, over enabled input pins, of sensed state AND mask. It rises after the fourth rising edge after a level-mode pin change, and after the fifth after an edge-mode pin change.
- R9: With function-enable set, the GPIO does not drive the pin, but an enabled input still senses it.
- R10: Register addresses are data 0, direction 1, input-enable 2, polarity 3, edge-select 4, both-edges 5, mask 6, function-enable 7, and clear 8 (write-one-to-clear, reads 0). Addresses 1 to 7 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | W | Write data |
| rdata | output | W | Read data for addr, combinational |
| pin_in | input | W | Pin levels as seen at the pads |
| pin_out | output | W | GPIO output value |
| pin_oe | output | W | GPIO output enable per pin |
| irq | output | 1 | Interrupt request |

## Verification
A wrong synchronizer depth moves a readback transition one clock early or late. The fixed-latency checks catch this within five cycles of any pin change. A lost or stuck sticky bit stays visible at the data readback until the next clear, and it also holds irq wrongly once the bit is masked. A corrupted direction or function-enable bit shows on pin_oe in the very next cycle, and it also changes which data bits a write can alter.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA  = 4'd0,
    REG_DIR   = 4'd1,
    REG_INEN  = 4'd2,
    REG_POLAR = 4'd3,
    REG_EDGE  = 4'd4,
    REG_BOTH  = 4'd5,
    REG_MASK  = 4'd6,
    REG_FUNC  = 4'd7,
    REG_CLR   = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 16,
  parameter int STAGES = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] s_new,
  output logic [W-1:0] s_old
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= '0;
      else        stg_q[g] <= stg_q[g-1];
    end
  end

  assign s_new = stg_q[STAGES-2];
  assign s_old = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_sense.sv
module gpio_bank_sense #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s_new,
  input  logic [W-1:0] s_old,
  input  logic [W-1:0] inen,
  input  logic [W-1:0] polar,
  input  logic [W-1:0] edge_sel,
  input  logic [W-1:0] both,
  input  logic [W-1:0] clr,
  input  logic [W-1:0] mask,
  output logic [W-1:0] sense_q,
  output logic [W-1:0] pend_q
);
  logic [W-1:0] sense_d;
  logic [W-1:0] pend_d;
  logic [W-1:0] det;
  logic [W-1:0] lvl;

  for (genvar b = 0; b < W; b++) begin : g_bit
    assign det[b] = both[b]  ? (s_new[b] ^ s_old[b]) :
                    polar[b] ? (s_old[b] & ~s_new[b]) :
                               (s_new[b] & ~s_old[b]);
    assign lvl[b] = s_new[b] ^ polar[b];
    assign sense_d[b] = inen[b] &
                        (edge_sel[b] ? ((sense_q[b] & ~clr[b]) | det[b]) : lvl[b]);
    assign pend_d[b] = sense_q[b] & mask[b] & inen[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      pend_q  <= '0;
    end else begin
      sense_q <= sense_d;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  localparam int SYNC_STAGES = 3;

  // reset: asserted at once, released after two clock edges
  logic rst_meta_q, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_core_n <= rst_meta_q;
    end
  end

  logic [W-1:0] data_q, dir_q, inen_q, polar_q, edge_q, both_q, mask_q, func_q;
  logic [W-1:0] data_d, dir_d, inen_d, polar_d, edge_d, both_d, mask_d, func_d;
  logic [W-1:0] clr_vec;

  always_comb begin
    data_d  = data_q;
    dir_d   = dir_q;
    inen_d  = inen_q;
    polar_d = polar_q;
    edge_d  = edge_q;
    both_d  = both_q;
    mask_d  = mask_q;
    func_d  = func_q;
    clr_vec = '0;
    if (wr_en) begin
      case (addr)
        REG_DATA:  data_d  = (data_q & ~dir_q) | (wdata & dir_q);
        REG_DIR:   dir_d   = wdata;
        REG_INEN:  inen_d  = wdata;
        REG_POLAR: polar_d = wdata;
        REG_EDGE:  edge_d  = wdata;
        REG_BOTH:  both_d  = wdata;
        REG_MASK:  mask_d  = wdata;
        REG_FUNC:  func_d  = wdata;
        REG_CLR:   clr_vec = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      inen_q  <= '0;
      polar_q <= '0;
      edge_q  <= '0;
      both_q  <= '0;
      mask_q  <= '0;
      func_q  <= '0;
    end else if (wr_en) begin
      data_q  <= data_d;
      dir_q   <= dir_d;
      inen_q  <= inen_d;
      polar_q <= polar_d;
      edge_q  <= edge_d;
      both_q  <= both_d;
      mask_q  <= mask_d;
      func_q  <= func_d;
    end
  end

  logic [W-1:0] s_new, s_old, sense_q, pend_q;

  gpio_bank_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pin_in & inen_q),
    .s_new (s_new),
    .s_old (s_old)
  );

  gpio_bank_sense #(.W(W)) u_sense (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .s_new    (s_new),
    .s_old    (s_old),
    .inen     (inen_q),
    .polar    (polar_q),
    .edge_sel (edge_q),
    .both     (both_q),
    .clr      (clr_vec),
    .mask     (mask_q),
    .sense_q  (sense_q),
    .pend_q   (pend_q)
  );

  // edge-mode requests take one extra stage
  logic edge_irq_d, edge_irq_q;
  assign edge_irq_d = |(pend_q & edge_q);

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) edge_irq_q <= 1'b0;
    else             edge_irq_q <= edge_irq_d;
  end

  assign irq     = (|(pend_q & ~edge_q)) | edge_irq_q;
  assign pin_out = data_q;
  assign pin_oe  = dir_q & ~func_q;

  always_comb begin
    case (addr)
      REG_DATA:  rdata = (data_q & dir_q) | (sense_q & ~dir_q);
      REG_DIR:   rdata = dir_q;
      REG_INEN:  rdata = inen_q;
      REG_POLAR: rdata = polar_q;
      REG_EDGE:  rdata = edge_q;
      REG_BOTH:  rdata = both_q;
      REG_MASK:  rdata = mask_q;
      REG_FUNC:  rdata = func_q;
      default:   rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      data_q,
  input logic [W-1:0]      dir_q,
  input logic [W-1:0]      inen_q,
  input logic [W-1:0]      edge_q,
  input logic [W-1:0]      mask_q,
  input logic [W-1:0]      sense_q,
  input logic              irq
);
  // R3: a data write leaves the input-pin bits untouched
  a_r3_input_bits_kept: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && addr == REG_DATA) |=>
      ((data_q & ~$past(dir_q)) == ($past(data_q) & ~$past(dir_q))));

  // R4: no sensed bit on a pin whose buffer was disabled
  a_r4_disabled_senses_zero: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((sense_q & ~$past(inen_q)) == '0));

  // R6: captured edges survive a cycle without any register write
  a_r6_sticky_holds: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!wr_en) |=>
      ((sense_q & $past(sense_q & edge_q & inen_q)) == $past(sense_q & edge_q & inen_q)));

  // R8: a request needs a mask bit set one or two cycles earlier
  a_r8_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq |-> (($past(mask_q) != '0) || ($past(mask_q, 2) != '0)));
endmodule

bind gpio_bank gpio_bank_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .wr_en      (wr_en),
  .addr       (addr),
  .data_q     (data_q),
  .dir_q      (dir_q),
  .inen_q     (inen_q),
  .edge_q     (edge_q),
  .mask_q     (mask_q),
  .sense_q    (sense_q),
  .irq        (irq)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = 4'd0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] pin_in = '0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  logic         irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_bank #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // behavioural reference
  logic [W-1:0] m_reg [9];
  logic [W-1:0] m_hist [$];
  logic [W-1:0] m_sense, m_pend;
  logic         m_epend;
  int           m_cnt;

  task automatic model_reset();
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    m_hist = {};
    for (int i = 0; i < 3; i++) m_hist.push_back('0);
    m_sense = '0; m_pend = '0; m_epend = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      model_reset();
      m_cnt = 0;
    end else begin
      if (m_cnt >= 2) begin
        logic [W-1:0] dir, inen, pol, edg, both, msk, clr, sn, so, det, lvl, nsense, npend;
        logic nep;
        dir = m_reg[1]; inen = m_reg[2]; pol = m_reg[3]; edg = m_reg[4];
        both = m_reg[5]; msk = m_reg[6];
        clr = (wr_en && addr == 4'd8) ? wdata : '0;
        sn = m_hist[1]; so = m_hist[2];
        for (int b = 0; b < W; b++) begin
          if (both[b])     det[b] = sn[b] != so[b];
          else if (pol[b]) det[b] = so[b] && !sn[b];
          else             det[b] = sn[b] && !so[b];
          lvl[b] = sn[b] ^ pol[b];
          nsense[b] = inen[b] && (edg[b] ? ((m_sense[b] && !clr[b]) || det[b]) : lvl[b]);
        end
        npend = m_sense & msk & inen;
        nep = |(m_pend & edg);
        m_sense = nsense; m_pend = npend; m_epend = nep;
        m_hist.push_front(pin_in & inen);
        void'(m_hist.pop_back());
        if (wr_en) begin
          if (addr == 4'd0) m_reg[0] = (m_reg[0] & ~dir) | (wdata & dir);
          else if (addr >= 4'd1 && addr <= 4'd7) m_reg[addr] = wdata;
        end
      end
      if (m_cnt < 3) m_cnt++;
    end
  end

  function automatic logic [W-1:0] m_rdata(input logic [3:0] a);
    if (a == 4'd0) return (m_reg[0] & m_reg[1]) | (m_sense & ~m_reg[1]);
    if (a >= 4'd1 && a <= 4'd7) return m_reg[a];
    return '0;
  endfunction

  task automatic check(input string req, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison, 5 ns after each rising edge
  always @(posedge clk) begin
    #5;
    if (!done) begin
      check((addr == 4'd0) ? "R3" : "R10", "rdata", rdata, m_rdata(addr));
      check("R2", "pin_out", pin_out, m_reg[0]);
      check("R9", "pin_oe", pin_oe, m_reg[1] & ~m_reg[7]);
      check("R8", "irq", {15'd0, irq}, {15'd0, (|(m_pend & ~m_reg[4])) | m_epend});
    end
  end

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 4'd0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #5;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 9; a++) begin
      addr = 4'(a); #1;
      check("R1", "reset rdata", rdata, '0);
    end
    check("R1", "reset pin_oe", pin_oe, '0);
    check("R1", "reset irq", {15'd0, irq}, '0);
    addr = 4'd0;

    // R4/R8: level latency on pin 0
    wr(4'd2, 16'h0001); wr(4'd6, 16'h0001);
    repeat (4) @(negedge clk);
    pin_in[0] = 1'b1;
    edges(2); check("R4", "bit0 after 2 edges", {15'd0, rdata[0]}, 16'd0);
    edges(1); check("R4", "bit0 after 3 edges", {15'd0, rdata[0]}, 16'd1);
    check("R8", "level irq after 3 edges", {15'd0, irq}, 16'd0);
    edges(1); check("R8", "level irq after 4 edges", {15'd0, irq}, 16'd1);
    @(negedge clk); pin_in[0] = 1'b0;
    wr(4'd2, 16'h0000);

    // R6/R8: edge latency on pin 1
    wr(4'd4, 16'h0002); wr(4'd6, 16'h0002); wr(4'd2, 16'h0002);
    repeat (4) @(negedge clk);
    pin_in[1] = 1'b1;
    edges(3); check("R6", "edge bit1 after 3 edges", {15'd0, rdata[1]}, 16'd1);
    edges(1); check("R8", "edge irq after 4 edges", {15'd0, irq}, 16'd0);
    edges(1); check("R8", "edge irq after 5 edges", {15'd0, irq}, 16'd1);
    @(negedge clk); pin_in[1] = 1'b0;
    edges(5); check("R6", "sticky after pin drop", {15'd0, rdata[1]}, 16'd1);
    wr(4'd8, 16'h0002);
    edges(1); check("R6", "cleared bit1", {15'd0, rdata[1]}, 16'd0);

    // R5: active-low level on pin 2
    wr(4'd3, 16'h0004); wr(4'd2, 16'h0006);
    edges(4); check("R5", "inverted level bit2", {15'd0, rdata[2]}, 16'd1);

    // R7: both-edges on pin 3 with falling-edge polarity
    wr(4'd4, 16'h000A); wr(4'd5, 16'h0008); wr(4'd3, 16'h000C); wr(4'd2, 16'h000E);
    @(negedge clk); pin_in[3] = 1'b1;
    edges(4); check("R7", "rise captured bit3", {15'd0, rdata[3]}, 16'd1);
    wr(4'd8, 16'h0008);
    edges(1); check("R7", "bit3 cleared", {15'd0, rdata[3]}, 16'd0);
    @(negedge clk); pin_in[3] = 1'b0;
    edges(4); check("R7", "fall captured bit3", {15'd0, rdata[3]}, 16'd1);

    // R9: function-enable keeps sensing, blocks drive
    wr(4'd7, 16'h0030); wr(4'd1, 16'h0010); wr(4'd2, 16'h002E);
    @(negedge clk); pin_in[5] = 1'b1;
    edges(4);
    check("R9", "owned pin4 oe", {15'd0, pin_oe[4]}, 16'd0);
    check("R9", "owned pin5 sensed", {15'd0, rdata[5]}, 16'd1);

    // R3: data write touches output bits only
    wr(4'd7, 16'h0000); wr(4'd1, 16'h00F0); wr(4'd0, 16'hFFFF);
    edges(0); check("R3", "pin_out after data write", pin_out, 16'h00F0);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (($urandom % 10) < 3) begin
        wr_en = 1'b1; addr = 4'($urandom % 9); wdata = 16'($urandom);
      end else begin
        wr_en = 1'b0; addr = 4'($urandom % 9);
      end
      if (($urandom % 5) == 0) pin_in = pin_in ^ (16'd1 << ($urandom % 16));
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule